// File: doc/BRIEF.md
# Transaction-Gated Bus Clock Generator

This block produces the clock driven onto an external parallel bus from the internal clock. The bus clock comes straight from a flop that toggles on each rising edge of `clk_i`. The bus clock therefore runs at half the internal rate, and each phase lasts exactly one internal cycle. In free-running mode the bus clock toggles for as long as the interface is enabled. In gated mode it idles high and toggles only around a transaction. It then stops on a rising edge, so a short pulse never reaches the pin.

The bus sequencer drives the strobes and a write-intent request. It reads back `clk_active_o` to learn whether the bus clock is running. With the early-start option (write two-cycle bit clear), a pending write starts the clock ahead of the write strobe. The sequencer waits for `clk_active_o` and then raises the strobe one bus cycle later. With the two-cycle bit set, and always for reads, the strobe itself starts the clock.

Top module: `bus_clk_gen`

## Requirements
- R1: With `if_en_i`=1 and `gate_en_i`=0, `bus_clk_o` inverts on every rising edge of `clk_i`, and `clk_active_o` is 1 after the first such edge.
- R2: During reset, `bus_clk_o`=1 and `clk_active_o`=0. After any rising edge of `clk_i` at which `if_en_i`=0, `bus_clk_o`=1 and `clk_active_o`=0.
- R3: In gated mode (`gate_en_i`=1), when no start condition is present and the clock is stopped, `bus_clk_o` stays 1 and `clk_active_o` stays 0.
- R4: In gated mode with `wr_2cyc_i`=0, an edge that samples `wr_req_i`=1 while the clock is stopped drives `bus_clk_o` to 0 and `clk_active_o` to 1.
- R5: In gated mode with `wr_2cyc_i`=1, `wr_req_i` has no effect. The clock starts (`bus_clk_o` to 0, `clk_active_o` to 1) at the edge that samples `wr_stb_i`=1.
- R6: In gated mode, any bit of `rd_stb_i` sampled at 1 starts the clock in the same way as R5, whatever the value of `wr_2cyc_i`.
- R7: In gated mode, once no start condition is present, the clock stops at its next rising transition. That edge sets `bus_clk_o` to 1 and clears `clk_active_o` together, and the clock then stays high.
- R8: `bus_clk_o` changes only at rising edges of `clk_i`, and every low phase lasts exactly one `clk_i` cycle.
- R9: While `clk_active_o`=1, `bus_clk_o`=1 and `if_en_i`=1, the next edge drives `bus_clk_o` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Internal clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| if_en_i | input | 1 | Interface enable |
| gate_en_i | input | 1 | 1 = gated mode, 0 = free-running |
| wr_2cyc_i | input | 1 | 1 = start on the write strobe, 0 = start on the write request |
| wr_req_i | input | 1 | Sequencer has a write pending (early-start trigger) |
| wr_stb_i | input | 1 | Write strobe level |
| rd_stb_i | input | NUM_RD | Read strobe levels, one per read source |
| bus_clk_o | output | 1 | Bus clock pin level |
| clk_active_o | output | 1 | Bus clock is toggling |

## Verification
The assertions take the inputs as synchronous to `clk_i` and stable around its rising edge. They do not assume that the sequencer follows the early-start handshake, so every check holds for arbitrary strobe and request patterns. The stimulus changes inputs only on the falling edge of `clk_i`. It mixes random mode bits, strobes and requests with directed idle, start and stop sequences. This covers mode changes in the middle of a transaction and strobes that drop during either clock phase.

// File: rtl/bus_clk_pkg.sv
package bus_clk_pkg;
  typedef struct packed {
    logic en;
    logic gated;
    logic wr_2cyc;
  } clk_mode_t;
endpackage

// File: rtl/bus_clk_start_sel.sv
module bus_clk_start_sel
  import bus_clk_pkg::*;
#(
  parameter int NUM_RD = 1
) (
  input  clk_mode_t         mode_i,
  input  logic              wr_req_i,
  input  logic              wr_stb_i,
  input  logic [NUM_RD-1:0] rd_stb_i,
  output logic              start_o
);
  logic early_wr;
  logic any_stb;

  assign any_stb  = wr_stb_i | (|rd_stb_i);
  // early start only for writes without the two-cycle option
  assign early_wr = wr_req_i & ~mode_i.wr_2cyc;
  assign start_o  = mode_i.en & (~mode_i.gated | any_stb | early_wr);
endmodule

// File: rtl/bus_clk_phase_gen.sv
module bus_clk_phase_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic start_i,
  output logic bus_clk_o,
  output logic active_o
);
  logic ph_q, run_q;
  logic ph_d, run_d;

  always_comb begin
    // stopped state always parks high; running stops only on a rise
    run_d = en_i & (start_i | (run_q & ph_q));
    ph_d  = (en_i & (run_q | start_i)) ? ~ph_q : 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= 1'b1;
      run_q <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      run_q <= run_d;
    end
  end

  assign bus_clk_o = ph_q;
  assign active_o  = run_q;

  assert_idle_high_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_o |-> bus_clk_o);

  assert_low_one_cycle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_clk_o |=> bus_clk_o);

  assert_stop_on_rise_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && !bus_clk_o && en_i && !start_i) |=> (bus_clk_o && !active_o));

  assert_run_falls_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && bus_clk_o && en_i) |=> !bus_clk_o);

  assert_disable_parks_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (bus_clk_o && !active_o));
endmodule

// File: rtl/bus_clk_gen.sv
module bus_clk_gen
  import bus_clk_pkg::*;
#(
  parameter int NUM_RD = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              if_en_i,
  input  logic              gate_en_i,
  input  logic              wr_2cyc_i,
  input  logic              wr_req_i,
  input  logic              wr_stb_i,
  input  logic [NUM_RD-1:0] rd_stb_i,
  output logic              bus_clk_o,
  output logic              clk_active_o
);
  clk_mode_t mode;
  logic      start;

  assign mode = '{en: if_en_i, gated: gate_en_i, wr_2cyc: wr_2cyc_i};

  bus_clk_start_sel #(.NUM_RD(NUM_RD)) u_start_sel (
    .mode_i   (mode),
    .wr_req_i (wr_req_i),
    .wr_stb_i (wr_stb_i),
    .rd_stb_i (rd_stb_i),
    .start_o  (start)
  );

  bus_clk_phase_gen u_phase (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (if_en_i),
    .start_i   (start),
    .bus_clk_o (bus_clk_o),
    .active_o  (clk_active_o)
  );

  assert_free_toggle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (if_en_i && !gate_en_i) |=> (clk_active_o && (bus_clk_o != $past(bus_clk_o))));

  assert_early_start_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (if_en_i && gate_en_i && !wr_2cyc_i && wr_req_i && !clk_active_o)
      |=> (!bus_clk_o && clk_active_o));

  assert_req_ignored_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (if_en_i && gate_en_i && wr_2cyc_i && !wr_stb_i && !(|rd_stb_i) && !clk_active_o)
      |=> (bus_clk_o && !clk_active_o));

  assert_rd_start_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (if_en_i && gate_en_i && (|rd_stb_i) && !clk_active_o)
      |=> (!bus_clk_o && clk_active_o));
endmodule

// File: tb/bus_clk_gen_bench.sv
module bus_clk_gen_bench;
  localparam int NUM_RD = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 0, gate = 0, w2 = 0, wreq = 0, wstb = 0;
  logic [NUM_RD-1:0] rstb = '0;
  logic bus_clk, active;

  int checks = 0, errors = 0;
  logic m_clk = 1'b1, m_act = 1'b0;
  logic prev_low = 1'b0;

  always #10 clk = ~clk;

  bus_clk_gen #(.NUM_RD(NUM_RD)) u_bus_clk_gen (
    .clk_i(clk), .rst_ni(rst_n), .if_en_i(en), .gate_en_i(gate),
    .wr_2cyc_i(w2), .wr_req_i(wreq), .wr_stb_i(wstb), .rd_stb_i(rstb),
    .bus_clk_o(bus_clk), .clk_active_o(active)
  );

  function automatic logic start_cond(logic e, logic g, logic t, logic rq, logic ws,
                                      logic [NUM_RD-1:0] rs);
    if (!e) return 1'b0;
    if (!g) return 1'b1;                 // R1 free-running
    if (ws || (|rs)) return 1'b1;        // R5 / R6 strobes
    return rq && !t;                     // R4 early start
  endfunction

  function automatic string pick_tag(logic e, logic g, logic t, logic rq, logic ws,
                                     logic [NUM_RD-1:0] rs, logic was_act);
    if (!e) return "R2";
    if (!g) return "R1";
    if (|rs && !was_act) return "R6";
    if (!was_act && ws) return "R5";
    if (!was_act && rq && !t) return "R4";
    if (!was_act && rq && t) return "R5";
    if (!was_act) return "R3";
    if (!start_cond(e, g, t, rq, ws, rs)) return "R7";
    return "R9";
  endfunction

  // advance the reference by one clk_i edge, using the inputs that were applied
  task automatic model_step();
    logic s;
    s = start_cond(en, gate, w2, wreq, wstb, rstb);
    if (!en) begin
      m_clk = 1'b1; m_act = 1'b0;
    end else if (s) begin
      m_clk = ~m_clk; m_act = 1'b1;
    end else if (m_act) begin
      // finish the running cycle: a rise stops the clock
      if (!m_clk) begin m_clk = 1'b1; m_act = 1'b0; end
      else m_clk = 1'b0;
    end else begin
      m_clk = 1'b1;
    end
  endtask

  task automatic check(string tag, logic act_v, logic exp_v, string what);
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act_v, exp_v);
    end
  endtask

  task automatic step_and_check();
    string tag;
    tag = pick_tag(en, gate, w2, wreq, wstb, rstb, m_act);
    @(negedge clk);
    model_step();
    check(tag, bus_clk, m_clk, "bus_clk_o");
    check(tag, active, m_act, "clk_active_o");
    if (prev_low) check("R8", bus_clk, 1'b1, "low phase length");
    prev_low = !bus_clk;
  endtask

  task automatic drive(logic e, logic g, logic t, logic rq, logic ws, logic [NUM_RD-1:0] rs);
    en = e; gate = g; w2 = t; wreq = rq; wstb = ws; rstb = rs;
  endtask

  initial begin
    void'($urandom(32'd4242));
    #25;
    check("R2", bus_clk, 1'b1, "reset bus_clk_o");
    check("R2", active, 1'b0, "reset clk_active_o");
    @(negedge clk); rst_n = 1'b1;

    // R3: gated idle stays high
    drive(1, 1, 0, 0, 0, '0);
    repeat (4) step_and_check();
    check("R3", bus_clk, 1'b1, "gated idle level");

    // R4: early start from a write request, sequencer strobe after a bus cycle
    drive(1, 1, 0, 1, 0, '0);
    step_and_check();
    check("R4", bus_clk, 1'b0, "early start level");
    check("R4", active, 1'b1, "early start active");
    step_and_check();
    drive(1, 1, 0, 1, 1, '0);
    repeat (4) step_and_check();
    drive(1, 1, 0, 0, 0, '0);
    repeat (3) step_and_check();
    check("R7", active, 1'b0, "stopped after strobe drop");
    check("R7", bus_clk, 1'b1, "parked high after stop");

    // R5: request ignored with two-cycle option
    drive(1, 1, 1, 1, 0, '0);
    repeat (3) step_and_check();
    check("R5", bus_clk, 1'b1, "request ignored level");
    check("R5", active, 1'b0, "request ignored active");
    drive(1, 1, 1, 1, 1, '0);
    step_and_check();
    check("R5", bus_clk, 1'b0, "strobe start level");
    drive(1, 1, 1, 0, 0, '0);
    repeat (2) step_and_check();

    // R6: read strobe starts regardless of two-cycle option
    drive(1, 1, 0, 0, 0, 2'b10);
    step_and_check();
    check("R6", active, 1'b1, "read start active");
    drive(1, 1, 0, 0, 0, '0);
    repeat (3) step_and_check();

    // R1: free-running
    drive(1, 0, 0, 0, 0, '0);
    repeat (6) step_and_check();

    // R2: disable while running
    drive(0, 0, 0, 0, 0, '0);
    step_and_check();
    check("R2", bus_clk, 1'b1, "disabled level");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      drive(r > 5, $urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1,
            $urandom_range(0, 3) == 0, $urandom_range(0, 4) == 0,
            NUM_RD'($urandom_range(0, 7) == 0 ? $urandom_range(1, 3) : 0));
      step_and_check();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule